// File: doc/BRIEF.md
# Accumulator Multicycle Instruction Sequencer

This block is a small accumulator machine whose control unit walks every instruction through a fixed chain of register transfers. It uses a program counter, a memory address register, a memory data register, an instruction register and one accumulator. Each instruction starts with the same fetch steps. The decode step then picks one of three paths: a read of the operand, a write of the operand, or a return straight to fetch. One state machine drives every transfer, and each transfer lasts exactly one clock cycle.

The core connects to an external synchronous single-port memory through an address, a write-data bus, a write enable and a read-data bus. A read returns its word one cycle after the address is presented. The memory data register carries words in both directions: it takes words read from memory and it holds the word being written. Two flags, carry and overflow, are output as a status field, and a halted output reports that sequencing has stopped.

Top module: `acc_seq_top`

## Requirements
- R1: While rst_ni is low, halted_o is 0, status_o is 0, mem_we_o is 0 and mem_addr_o is 0. After reset is released, the first instruction is fetched from address 0.
- R2: An instruction word is 12 bits: bits [11:8] hold the opcode and bits [7:0] hold the operand address. Opcode 0 is halt, 1 is load, 2 is store and 3 is add. The program counter advances by one for every instruction, so instructions run in address order.
- R3: A load copies the memory word at the operand address into the accumulator. A load or an add takes 8 clock cycles from the start of its fetch to the start of the next fetch.
- R4: A store drives mem_we_o high for exactly one cycle, with mem_addr_o set to the operand address and mem_wdata_o set to the accumulator. A store takes 6 clock cycles.
- R5: An add replaces the accumulator with the accumulator plus the operand word, modulo 2^12.
- R6: An add sets status_o[0] (carry) to the carry out of bit 11 of that sum.
- R7: An add sets status_o[1] (overflow) to 1 exactly when both addends have the same sign bit and the sum's sign bit differs from it.
- R8: Load, store, no-operation and halt leave status_o unchanged.
- R9: Opcodes 4 to 15 act as no-operations: they change neither the accumulator nor memory, and each takes 5 cycles before the next fetch begins.
- R10: A halt raises halted_o 5 cycles after its fetch begins. halted_o then stays high until reset, with no further memory write and mem_addr_o held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address, taken from the memory address register |
| mem_wdata_o | output | 12 | Write data, taken from the memory data register |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 12 | Memory read data, valid one cycle after the address |
| halted_o | output | 1 | High once a halt instruction has executed |
| status_o | output | 2 | Bit 0 is carry, bit 1 is overflow |

## Verification
Six programs are run, each from its own reset. The first mixes loads, adds, a store and a read-back of the stored word, which shows that operand addressing and the transfer from accumulator to memory data register work. Three short add programs cover carry without overflow, overflow without carry, and both together, so that a wrong carry tap or a wrong sign rule is caught. A further program places no-operations and a load after an overflowing add, which shows the flags are held and the no-operation timing is right. The last program puts a store after a halt at address 0, so any write after halt is caught. Each program's expected writes, flags and cycle count come from an instruction-level model of the requirements.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  typedef enum logic [3:0] {
    ST_F_MAR, ST_F_WAIT, ST_F_MDR, ST_F_IR, ST_DECODE,
    ST_R_WAIT, ST_R_MDR, ST_EXEC, ST_WRITE, ST_HALT
  } state_t;

  localparam int unsigned OP_HALT  = 0;
  localparam int unsigned OP_LOAD  = 1;
  localparam int unsigned OP_STORE = 2;
  localparam int unsigned OP_ADD   = 3;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_from_mdr;
    logic pc_inc;
    logic acc_from_mdr;
    logic acc_add;
    logic mem_we;
  } ctrl_t;
endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide    = {1'b0, a_i} + {1'b0, b_i};
    sum_o   = wide[DATA_W-1:0];
    carry_o = wide[DATA_W];
    ovf_o   = (a_i[DATA_W-1] == b_i[DATA_W-1]) && (wide[DATA_W-1] != a_i[DATA_W-1]);
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int unsigned OPC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o,
  output logic             halted_o
);
  state_t state_q, state_d;
  logic is_halt, is_load, is_store, is_add;

  assign is_halt  = opcode_i == OPC_W'(OP_HALT);
  assign is_load  = opcode_i == OPC_W'(OP_LOAD);
  assign is_store = opcode_i == OPC_W'(OP_STORE);
  assign is_add   = opcode_i == OPC_W'(OP_ADD);

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    case (state_q)
      ST_F_MAR:  begin ctrl_o.mar_from_pc = 1'b1; state_d = ST_F_WAIT; end
      ST_F_WAIT: state_d = ST_F_MDR;
      ST_F_MDR:  begin ctrl_o.mdr_from_mem = 1'b1; state_d = ST_F_IR; end
      ST_F_IR: begin
        ctrl_o.ir_from_mdr = 1'b1;
        ctrl_o.pc_inc      = 1'b1;
        state_d            = ST_DECODE;
      end
      ST_DECODE: begin
        if (is_halt) begin
          state_d = ST_HALT;
        end else if (is_load || is_add) begin
          ctrl_o.mar_from_ir = 1'b1;
          state_d            = ST_R_WAIT;
        end else if (is_store) begin
          ctrl_o.mar_from_ir  = 1'b1;
          ctrl_o.mdr_from_acc = 1'b1;
          state_d             = ST_WRITE;
        end else begin
          state_d = ST_F_MAR;  // unused opcode: no-op
        end
      end
      ST_R_WAIT: state_d = ST_R_MDR;
      ST_R_MDR:  begin ctrl_o.mdr_from_mem = 1'b1; state_d = ST_EXEC; end
      ST_EXEC: begin
        if (is_load) ctrl_o.acc_from_mdr = 1'b1;
        else         ctrl_o.acc_add      = 1'b1;
        state_d = ST_F_MAR;
      end
      ST_WRITE:  begin ctrl_o.mem_we = 1'b1; state_d = ST_F_MAR; end
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_MAR;
    else         state_q <= state_d;
  end

  assign halted_o = state_q == ST_HALT;
endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned OPC_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  ctrl_t                    ctrl_i,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [DATA_W-OPC_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  output logic                     mem_we_o,
  output logic [OPC_W-1:0]         opcode_o,
  output logic [1:0]               status_o
);
  localparam int unsigned ADDR_W = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q, sum;
  logic              carry_q, ovf_q, carry_n, ovf_n;

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (acc_q),
    .b_i     (mdr_q),
    .sum_o   (sum),
    .carry_o (carry_n),
    .ovf_o   (ovf_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ctrl_i.mar_from_pc)      mar_q <= pc_q;
      else if (ctrl_i.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (ctrl_i.mdr_from_mem)      mdr_q <= mem_rdata_i;
      else if (ctrl_i.mdr_from_acc) mdr_q <= acc_q;
      if (ctrl_i.ir_from_mdr) ir_q <= mdr_q;
      if (ctrl_i.pc_inc)      pc_q <= pc_q + 1'b1;
      if (ctrl_i.acc_from_mdr) begin
        acc_q <= mdr_q;
      end else if (ctrl_i.acc_add) begin
        acc_q   <= sum;
        carry_q <= carry_n;
        ovf_q   <= ovf_n;
      end
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mdr_q;
  assign mem_we_o    = ctrl_i.mem_we;
  assign opcode_o    = ir_q[DATA_W-1 -: OPC_W];
  assign status_o    = {ovf_q, carry_q};
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned OPC_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic [DATA_W-OPC_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic                    mem_we_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    halted_o,
  output logic [1:0]              status_o
);
  ctrl_t            ctl;
  logic [OPC_W-1:0] opcode;

  acc_seq_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .ctrl_o   (ctl),
    .halted_o (halted_o)
  );

  acc_seq_dp #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctl),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .opcode_o    (opcode),
    .status_o    (status_o)
  );
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halted_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [1:0]        status_i,
  input logic              add_en_i
);
  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  // R10
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);

  // R10
  halt_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(mem_addr_i));

  // R4
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_en_i |=> $stable(status_i));
endmodule

bind acc_seq_top acc_seq_chk #(.ADDR_W(DATA_W - OPC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halted_i   (halted_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .status_i   (status_o),
  .add_en_i   (ctl.acc_add)
);

// File: tb/tb_acc_seq_top.sv
`timescale 1ns/1ps
module tb_acc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [1:0]  status;

  logic [11:0] mem [256];
  logic [11:0] img [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [11:0] ld_d = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] a; logic [11:0] d; } wr_t;
  wr_t exp_q[$];

  always #5 clk = ~clk;

  acc_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .halted_o(halted), .status_o(status)
  );

  always_ff @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // monitor: every write must match the next expected one (R4)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected write addr %h data %h, expected none", mem_addr, mem_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d) begin
          errors++;
          $display("FAIL R4 write actual %h:%h expected %h:%h", mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [11:0] ins(input int op, input int a);
    return {op[3:0], a[7:0]};
  endfunction

  int exp_cyc;
  logic exp_c, exp_v;

  // instruction-level model: pushes expected writes, computes flags and cycles
  task automatic model();
    logic [11:0] m [256];
    logic [7:0]  pc = '0;
    logic [11:0] acc = '0;
    logic [12:0] s;
    for (int i = 0; i < 256; i++) m[i] = img[i];
    exp_c = 1'b0; exp_v = 1'b0; exp_cyc = 0;
    for (int n = 0; n < 300; n++) begin
      logic [3:0] op;
      logic [7:0] a;
      op = m[pc][11:8]; a = m[pc][7:0]; pc = pc + 8'd1;
      if (op == 4'd0) begin exp_cyc += 5; break; end
      else if (op == 4'd1) begin acc = m[a]; exp_cyc += 8; end
      else if (op == 4'd2) begin
        wr_t w;
        m[a] = acc; w.a = a; w.d = acc; exp_q.push_back(w); exp_cyc += 6;
      end else if (op == 4'd3) begin
        s = {1'b0, acc} + {1'b0, m[a]};
        exp_c = s[12];
        exp_v = (acc[11] == m[a][11]) && (s[11] != acc[11]);
        acc = s[11:0]; exp_cyc += 8;
      end else exp_cyc += 5;
    end
  endtask

  task automatic run_prog(input string req);
    int n;
    logic [7:0] a0;
    bit ok;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      ld_en = 1'b1; ld_a = i[7:0]; ld_d = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    exp_q.delete();
    model();
    chk("R1 halted in reset", int'(halted), 0);
    chk("R1 status in reset", int'(status), 0);
    chk("R1 we in reset", int'(mem_we), 0);
    chk("R1 addr in reset", int'(mem_addr), 0);
    rst_n = 1'b1;
    n = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (halted) break;
    end
    chk({req, " R10 cycles to halt"}, n, exp_cyc);
    chk({req, " R6 carry"}, int'(status[0]), int'(exp_c));
    chk({req, " R7 overflow"}, int'(status[1]), int'(exp_v));
    chk({req, " R4 pending writes"}, exp_q.size(), 0);
    a0 = mem_addr; ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (!halted || mem_addr !== a0 || mem_we) ok = 1'b0;
    end
    chk({req, " R10 halt held"}, int'(ok), 1);
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 R5 R2: loads, adds, store and read-back
    clear_img();
    img[0] = ins(1, 8'h40); img[1] = ins(3, 8'h41); img[2] = ins(2, 8'h50);
    img[3] = ins(1, 8'h50); img[4] = ins(3, 8'h42); img[5] = ins(2, 8'h51);
    img[6] = ins(0, 0);
    img[8'h40] = 12'h123; img[8'h41] = 12'h234; img[8'h42] = 12'h001;
    run_prog("R3 R5 basic");
    // R6 carry without overflow
    clear_img();
    img[0] = ins(1, 8'h80); img[1] = ins(3, 8'h81); img[2] = ins(2, 8'h90); img[3] = ins(0, 0);
    img[8'h80] = 12'hFFF; img[8'h81] = 12'h001;
    run_prog("R6 carry");
    // R7 overflow without carry
    img[8'h80] = 12'h7FF; img[8'h81] = 12'h001;
    run_prog("R7 overflow");
    // R6 R7 both set
    img[8'h80] = 12'h800; img[8'h81] = 12'h800;
    run_prog("R6 R7 both");
    // R8 R9: flags held across no-ops, load and stores
    clear_img();
    img[0] = ins(1, 8'h44); img[1] = ins(3, 8'h45); img[2] = ins(7, 8'h45);
    img[3] = ins(1, 8'h46); img[4] = ins(15, 8'h46); img[5] = ins(2, 8'h52);
    img[6] = ins(4, 8'h00); img[7] = ins(2, 8'h53); img[8] = ins(0, 0);
    img[8'h44] = 12'h7FF; img[8'h45] = 12'h001; img[8'h46] = 12'h005;
    run_prog("R8 R9 hold");
    // R10 halt at address 0, store after it must not run
    clear_img();
    img[0] = ins(0, 0); img[1] = ins(2, 8'h60);
    run_prog("R10 halt first");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule